// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a receive MAC and moves each incoming frame, delivered as a byte stream, into system memory. Memory holds a ring of two-word descriptors. The first word holds a buffer address, and its two low bits carry flags. The second word holds status. Each buffer is exactly 128 bytes. A frame that does not fit in one buffer continues into the next descriptors, and it may run from the last descriptor back to the first.

For each buffer the block reads the descriptor's address word and checks that the buffer belongs to hardware. It then stores bytes one at a time, using byte enables. When the buffer fills or the frame ends, it writes the status word. Only after that does it write the address word back with the ownership bit set.

Software sets the ring base by writing the queue pointer input. Software frees a descriptor by clearing its ownership bit. If the block needs a descriptor that software still owns, it discards the rest of the frame and pulses a no-buffer flag.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `rx_ready`, `mem_rd`, `mem_wr` and `nobuf` are all 0. The ring pointer is 0 and no memory access takes place until a byte is offered.
- R2: A write on `qptr_we` loads the ring base and the current descriptor pointer from `qptr_wdata` with bits 2:0 cleared. The next descriptor fetch reads that address.
- R3: A descriptor fetch reads the address word at the current pointer, with read data returned one cycle later. Bit 0 = 0 means the buffer is free for hardware. The buffer address is the word with bits 1:0 cleared.
- R4: Frame bytes are stored in arrival order, one byte per cycle, at buffer address + offset. The byte lane equals the address bits 1:0. A buffer takes exactly 128 bytes. A longer frame continues in the following descriptors.
- R5: Status word layout:
  - Bit 14 is set only in the buffer that holds the frame's first byte.
  - Bit 15 is set only in the buffer that holds its last byte.
  - Bits 11:0 hold the total frame length in the last buffer, and 0 elsewhere.
  - In the last buffer, bit 31 = `rx_info[5]` (broadcast), bits 26:23 = `rx_info[4:1]` (address-match 4..1, where `rx_info[1]` is match 1 at bit 23), and bit 22 = `rx_info[0]` (type-ID match). In other buffers these bits are 0.
- R6: The status word (at descriptor + 4) is written in the cycle before the address word. The address word is written back with bit 0 set and all other bits unchanged.
- R7: After a descriptor whose address word has bit 1 set, the next descriptor is the ring base. Otherwise it is the current descriptor + 8.
- R8: If a fetched address word has bit 0 = 1, `nobuf` pulses for one cycle. The remaining bytes of the current frame are accepted and discarded, and that descriptor is left untouched. The next frame starts with a fresh fetch of the same descriptor.
- R9: A frame longer than two buffers is stored across three descriptors, including across the ring wrap. It gets the start flag in the first descriptor, neither flag in the middle one, and end flag plus length in the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qptr_we | input | 1 | Load ring base from `qptr_wdata` |
| qptr_wdata | input | 32 | Ring base address (bits 2:0 ignored) |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Block accepts the byte this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the frame's last |
| rx_info | input | 6 | Match flags, sampled with the last byte |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address (word-aligned for words) |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| nobuf | output | 1 | One-cycle pulse: descriptor owned by software |

## Verification
A wrong ring pointer shows up at once in memory: the next frame's bytes and status land in the wrong buffer, and the bench detects this by inspecting every descriptor after each frame. A miscounted buffer offset moves bytes across the 128-byte boundary, which the checks on the last and first byte of adjacent buffers catch. A lost start or end flag, or a wrong length, is visible in the status word within two cycles of the frame's last byte. A wrong ownership decision appears as a `nobuf` pulse count that differs from what the bench expects, or as a software-owned descriptor that gets overwritten.

// File: rtl/rxr_pkg.sv
// Package: shared state type, descriptor bit positions and status-word builder
// for the receive descriptor ring writer. Assumes a 32-bit descriptor word.
package rxr_pkg;

    localparam int LEN_W     = 12;   // width of the frame-length field
    localparam int ADDR_OWN  = 0;    // address word: hardware has filled buffer
    localparam int ADDR_WRAP = 1;    // address word: last descriptor in ring
    localparam int ST_SOF    = 14;
    localparam int ST_EOF    = 15;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_FILL, S_STAT, S_OWN, S_DROP
    } rxr_state_e;

    // Builds the status word; length and match flags only go in the end buffer.
    function automatic logic [31:0] build_status(
        input logic             sof,
        input logic             eof,
        input logic [LEN_W-1:0] len,
        input logic [5:0]       info
    );
        logic [31:0] s;
        s         = '0;
        s[ST_SOF] = sof;
        s[ST_EOF] = eof;
        if (eof) begin
            s[LEN_W-1:0] = len;
            s[26:22]     = info[4:0];
            s[31]        = info[5];
        end
        return s;
    endfunction

endpackage

// File: rtl/rxr_desc_ptr.sv
// Module: rxr_desc_ptr
// Holds the ring base and the current descriptor address. A load takes a new
// base (8-byte aligned); an advance steps by one descriptor or returns to base
// when the finished descriptor carried the wrap marker.
module rxr_desc_ptr #(
    parameter int AW        = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    localparam int ALIGN_W = $clog2(DESC_BYTES);

    logic [AW-1:0] base;

    // Base and pointer registers: load wins over advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            cur  <= '0;
        end else if (load) begin
            base <= {load_addr[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
            cur  <= {load_addr[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end else if (advance) begin
            cur  <= wrap ? base : cur + AW'(DESC_BYTES);
        end
    end

    // R2: after a load the pointer sits on the aligned new base.
    p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == base) && (cur[ALIGN_W-1:0] == '0));

endmodule

// File: rtl/rxr_byte_ctr.sv
// Module: rxr_byte_ctr
// Tracks the byte offset within the current buffer and the running frame
// length. Assumes BUF_BYTES is a power of two of at least 4.
module rxr_byte_ctr #(
    parameter int BUF_BYTES = 128,
    parameter int LEN_W     = 12,
    localparam int OFF_W    = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clr,
    input  logic             buf_clr,
    input  logic             step,
    output logic [OFF_W-1:0] off,
    output logic [LEN_W-1:0] len,
    output logic             at_end
);
    // Offset register: cleared for each new buffer, bumped per stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_clr) off <= '0;
        else if (step)         off <= off + 1'b1;
    end

    // Length register: cleared at frame start, bumped per stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_clr) len <= '0;
        else if (step)           len <= len + 1'b1;
    end

    assign at_end = (off == OFF_W'(BUF_BYTES - 1));

endmodule

// File: rtl/rx_ring_writer.sv
// Module: rx_ring_writer (top)
// Stores a received byte stream into a ring of fixed-size buffers described
// by two-word descriptors. Assumes a memory port with one-cycle read latency,
// no wait states, and byte-enabled writes; the queue pointer is written while
// no frame is in progress.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BUF_BYTES = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          qptr_we,
    input  logic [AW-1:0] qptr_wdata,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic [5:0]    rx_info,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          nobuf
);
    localparam int OFF_W = $clog2(BUF_BYTES);

    rxr_state_e    state, state_nx;
    logic [AW-1:0] cur_desc;
    logic [AW-1:0] buf_base;
    logic [31:0]   addr_word;
    logic          sof_q, eof_q;
    logic [5:0]    info_q;
    logic [OFF_W-1:0] off;
    logic [LEN_W-1:0] len;
    logic          at_end, accept, owned;

    assign accept = rx_valid && rx_ready;
    assign owned  = mem_rdata[ADDR_OWN];

    rxr_desc_ptr #(.AW(AW), .DESC_BYTES(8)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (qptr_we),
        .load_addr(qptr_wdata),
        .advance  (state == S_OWN),
        .wrap     (addr_word[ADDR_WRAP]),
        .cur      (cur_desc)
    );

    rxr_byte_ctr #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_clr(state == S_IDLE),
        .buf_clr  (state == S_CHECK),
        .step     (state == S_FILL && accept),
        .off      (off),
        .len      (len),
        .at_end   (at_end)
    );

    // Next-state decision for the descriptor and fill sequence.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE:  if (rx_valid) state_nx = S_FETCH;
            S_FETCH: state_nx = S_CHECK;
            S_CHECK: state_nx = owned ? S_DROP : S_FILL;
            S_FILL:  if (accept && (rx_last || at_end)) state_nx = S_STAT;
            S_STAT:  state_nx = S_OWN;
            S_OWN:   state_nx = eof_q ? S_IDLE : S_FETCH;
            S_DROP:  if (accept && rx_last) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Per-buffer context: buffer base, raw address word, frame flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_base  <= '0;
            addr_word <= '0;
            sof_q     <= 1'b0;
            eof_q     <= 1'b0;
            info_q    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    sof_q <= 1'b1;
                    eof_q <= 1'b0;
                end
                S_CHECK: if (!owned) begin
                    addr_word <= mem_rdata;
                    buf_base  <= AW'({mem_rdata[31:2], 2'b00});
                end
                S_FILL: if (accept && rx_last) begin
                    eof_q  <= 1'b1;
                    info_q <= rx_info;
                end
                S_OWN:  sof_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Memory port and stream handshake driven from the state.
    always_comb begin
        rx_ready  = (state == S_FILL) || (state == S_DROP);
        nobuf     = (state == S_CHECK) && owned;
        mem_rd    = (state == S_FETCH);
        mem_wr    = 1'b0;
        mem_addr  = cur_desc;
        mem_be    = 4'hF;
        mem_wdata = '0;
        case (state)
            S_FILL: begin
                mem_wr    = accept;
                mem_addr  = buf_base + AW'({off[OFF_W-1:2], 2'b00});
                mem_be    = 4'b0001 << off[1:0];
                mem_wdata = {4{rx_data}};
            end
            S_STAT: begin
                mem_wr    = 1'b1;
                mem_addr  = cur_desc + AW'(4);
                mem_wdata = build_status(sof_q, eof_q, len, info_q);
            end
            S_OWN: begin
                mem_wr    = 1'b1;
                mem_wdata = addr_word | 32'h1;
            end
            default: ;
        endcase
    end

    // R3: a cycle never both reads and writes memory.
    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6: the ownership write-back follows the status write to the same descriptor.
    p_own_after_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OWN) |-> $past(mem_wr && mem_addr == cur_desc + AW'(4)));

    // R4: every byte write lands inside the current buffer.
    p_byte_in_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_be != 4'hF) |-> ((mem_addr - buf_base) < AW'(BUF_BYTES)));

    // R8: after a no-buffer pulse, bytes are taken but nothing is written.
    p_nobuf_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nobuf |=> (rx_ready && !mem_wr && !nobuf));

endmodule

// File: tb/rx_ring_writer_tb.sv
// Directed bench for rx_ring_writer: four-descriptor ring at address 0,
// buffers at 0x100 + 0x80*i, descriptor 3 carries the wrap marker.
module rx_ring_writer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qptr_we = 1'b0;
    logic [31:0] qptr_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [5:0]  rx_info = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        nobuf;

    int checks = 0;
    int errors = 0;
    int nobuf_cnt = 0;
    bit done = 1'b0;

    logic [31:0] mem [0:191];

    always #5 clk = ~clk;

    rx_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .qptr_we(qptr_we), .qptr_wdata(qptr_wdata),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_info(rx_info), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .nobuf(nobuf)
    );

    // Memory model: one-cycle read latency, byte-enabled writes.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_wr)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (rst_n && nobuf) nobuf_cnt <= nobuf_cnt + 1;
    end

    function automatic logic [7:0] byte_at(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Sends one frame of len bytes with data seed+i; info goes with the last byte.
    task automatic send_frame(input int len, input logic [7:0] seed, input logic [5:0] info);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = seed + 8'(i);
            rx_last  = (i == len - 1);
            rx_info  = (i == len - 1) ? info : 6'h0;
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic chk_bytes(input string req, input int base, input int first,
                             input int cnt, input logic [7:0] seed);
        int bad = 0;
        for (int i = 0; i < cnt; i++)
            if (byte_at(base + i) !== seed + 8'(first + i)) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 rx_ready", {31'd0, rx_ready}, 32'd0);
        chk("R1 mem_rd/mem_wr", {30'd0, mem_rd, mem_wr}, 32'd0);
        chk("R1 nobuf", {31'd0, nobuf}, 32'd0);
    endtask

    task automatic t_short_frame;
        // R2: base written with low bits set must still land on descriptor 0.
        @(negedge clk);
        qptr_we = 1'b1; qptr_wdata = 32'h0000_0005;
        @(negedge clk);
        qptr_we = 1'b0;
        send_frame(60, 8'h10, 6'b100001);
        chk_bytes("R4 short frame bytes", 32'h100, 0, 60, 8'h10);
        chk("R4 byte past frame untouched", 32'(byte_at(32'h100 + 60)), 32'd0);
        chk("R5 short status", mem[1], 32'h8040_C03C);
        chk("R6 desc0 owned", mem[0], 32'h0000_0101);
        chk("R2 first fetch at aligned base", mem[3], 32'h0);
    endtask

    task automatic t_full_buffer;
        send_frame(128, 8'hA0, 6'b000010);
        chk_bytes("R4 128-byte buffer", 32'h180, 0, 128, 8'hA0);
        chk("R5 exact-fit status", mem[3], 32'h0080_C080);
        chk("R6 desc1 owned", mem[2], 32'h0000_0181);
        chk("R7 desc2 untouched", mem[4], 32'h0000_0200);
        chk("R1 idle after frame", {31'd0, rx_ready}, 32'd0);
    endtask

    task automatic t_drop_whole;
        mem[4] = 32'h0000_0201;
        send_frame(50, 8'h55, 6'h3F);
        chk("R8 one nobuf pulse", 32'(nobuf_cnt), 32'd1);
        chk("R8 desc2 status untouched", mem[5], 32'h0);
        chk("R8 buffer2 untouched", 32'(byte_at(32'h200)), 32'd0);
        chk("R8 desc2 addr untouched", mem[4], 32'h0000_0201);
        mem[4] = 32'h0000_0200;
    endtask

    task automatic t_wrap_frame;
        mem[0] = 32'h0000_0100; mem[1] = 32'h0;
        send_frame(300, 8'h40, 6'h00);
        chk("R9 first desc status", mem[5], 32'h0000_4000);
        chk("R9 middle desc status", mem[7], 32'h0);
        chk("R7 wrap marker kept", mem[6], 32'h0000_0283);
        chk("R9 last desc status", mem[1], 32'h0000_812C);
        chk_bytes("R9 bytes buffer2", 32'h200, 0, 128, 8'h40);
        chk_bytes("R3 bytes buffer3 masked address", 32'h280, 128, 128, 8'h40);
        chk_bytes("R9 bytes buffer0 after wrap", 32'h100, 256, 44, 8'h40);
        chk("R4 buffer0 tail kept", 32'(byte_at(32'h100 + 44)), 32'(8'h10 + 8'd44));
    endtask

    task automatic t_drop_midframe;
        logic [31:0] st2;
        mem[2] = 32'h0000_0180; mem[3] = 32'h0;
        st2 = mem[5];
        send_frame(200, 8'h80, 6'h21);
        chk("R8 mid-frame nobuf pulse", 32'(nobuf_cnt), 32'd2);
        chk("R8 partial desc status", mem[3], 32'h0000_4000);
        chk_bytes("R8 partial bytes", 32'h180, 0, 128, 8'h80);
        chk("R8 owned desc2 left alone", mem[5], st2);
        mem[4] = 32'h0000_0200; mem[5] = 32'h0;
        send_frame(20, 8'h20, 6'h00);
        chk("R8 retry same descriptor", mem[5], 32'h0000_C014);
        chk_bytes("R8 retry bytes", 32'h200, 0, 20, 8'h20);
    endtask

    initial begin
        for (int i = 0; i < 192; i++) mem[i] = '0;
        mem[0] = 32'h0000_0100;
        mem[2] = 32'h0000_0180;
        mem[4] = 32'h0000_0200;
        mem[6] = 32'h0000_0282;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short_frame();
        t_full_buffer();
        t_drop_whole();
        t_wrap_frame();
        t_drop_midframe();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual running expected done");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule